// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block walks a ring of transmit descriptors in memory and turns the descriptors that hardware owns into a stream of buffer fragments. A start pulse launches a walk at the current queue pointer. The walker fetches descriptors one after another through a word-wide memory port. Each descriptor that hardware owns and that is well formed becomes one output beat, made of the buffer address, the byte length and a flag for the final fragment of the frame. When the final fragment has been emitted, the walker reads the first descriptor of that frame back from memory. It sets the ownership flag in that descriptor, writes it back, and moves the queue pointer past the frame. It then goes on with the next frame.

The walk stops at the first descriptor that software owns. It also stops, with a one-cycle error pulse, at a descriptor whose address or length is zero, or when the frame would grow past the byte budget. The descriptor stride is 8, 16 or 24 bytes, chosen by two configuration bits. Those bits are captured when a walk is launched. A start pulse that arrives during a walk is held and serviced when that walk ends. The walker moves no payload bytes.

Top module: `tx_desc_walker`

## Requirements
- R1: While reset is applied, busy, frag_valid, frame_done, both error pulses and mem_req are 0. The queue pointer takes the value of ring_base.
- R2: The descriptor stride in bytes is 8, plus 8 when cfg_word bit 30 (wide addressing) is 1, plus 8 when cfg_word bit 29 (extended descriptor) is 1. Each descriptor fetch reads word 0 and word 1, and also reads word 2 when bit 30 is 1. No other cfg_word bit has any effect. The configuration is captured when the walk is launched.
- R3: The walk goes on while bit 31 (hardware-released flag) of descriptor word 1 is 0. A descriptor with that bit set to 1 ends the walk with no fragment, no error pulse and no write.
- R4: Each accepted descriptor gives exactly one frag_valid beat. frag_addr is word 0, with word 2 in bits 63:32 when wide addressing is on and zero there otherwise. frag_len is word 1 bits 13:0. frag_last is word 1 bit 15.
- R5: A descriptor with a zero buffer address or a zero length raises err_invalid for one cycle, emits no fragment and ends the walk. The queue pointer keeps its value.
- R6: After the fragment that has frag_last set, the walker reads word 1 of the frame's first descriptor, writes it back with bit 31 set and all other bits unchanged, and then pulses frame_done. That is the only write made for each frame.
- R7: After a frame, q_ptr becomes ring_base if the last descriptor has bit 30 (wrap) of word 1 set. Otherwise q_ptr becomes that descriptor's address plus the stride.
- R8: Inside a frame, the next descriptor is fetched at ring_base when the current descriptor has wrap set. Otherwise it is fetched at the current address plus the stride.
- R9: A frame may hold up to 2048 bytes in total. A descriptor that would push the total past 2048 raises err_oversize for one cycle, emits no fragment and ends the walk, and q_ptr keeps its value.
- R10: A start pulse that arrives while busy is held, and it launches a new walk from the current q_ptr once the running walk ends.
- R11: A single walk processes several frames in sequence until it reaches a stop condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 32 | Configuration; bit 30 selects wide addressing, bit 29 selects extended descriptors |
| ring_base | input | ADDR_W | Byte address of the first descriptor in the ring |
| start | input | 1 | One-cycle request to walk the ring |
| mem_req | output | 1 | Memory access strobe, one word per cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address of the accessed word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the cycle after a read strobe |
| frag_valid | output | 1 | Fragment beat valid |
| frag_addr | output | 64 | Fragment buffer address |
| frag_len | output | 14 | Fragment length in bytes |
| frag_last | output | 1 | Fragment closes its frame |
| frame_done | output | 1 | Frame handed back to software |
| err_invalid | output | 1 | Zero address or zero length descriptor found |
| err_oversize | output | 1 | Frame byte budget exceeded |
| q_ptr | output | ADDR_W | Current queue pointer |
| busy | output | 1 | A walk is in progress |

## Verification
Directed rings cover each stride setting, a chain of two frames that wraps back to an already released first descriptor, and a two-descriptor loop that wraps inside one frame until the byte budget stops it. Separate directed rings stop the walk on a released descriptor, on a zero length, on a zero address, and at exactly 2048 bytes against 2049 bytes. These tell the four stop reasons apart from the frame-completion path. A held second start is driven into a ring that stops on an invalid descriptor, so the second walk shows up as a repeated error and repeated reads. Random rings with random configuration words, lengths, end markers and occasional released or invalid entries are compared against a bench model on every fragment, on the read and write counts, on the final pointer and on the memory contents after write-back.

// File: rtl/tx_walk_pkg.sv
package tx_walk_pkg;

    localparam int WORD_W       = 32;
    localparam int BUF_W        = 2 * WORD_W;
    localparam int LEN_W        = 14;
    localparam int FETCH_MAX    = 3;
    localparam int CFG_WIDE_BIT = 30;
    localparam int CFG_EXT_BIT  = 29;
    localparam int W1_USED_BIT  = 31;
    localparam int W1_WRAP_BIT  = 30;
    localparam int W1_LAST_BIT  = 15;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_CAP,
        ST_EVAL,
        ST_FB_REQ,
        ST_FB_CAP,
        ST_FB_WR,
        ST_ADV
    } walk_state_t;

    typedef struct packed {
        logic wide;
        logic ext;
    } walk_cfg_t;

    typedef struct packed {
        logic             used;
        logic             wrap;
        logic             last;
        logic [LEN_W-1:0] len;
        logic [BUF_W-1:0] buf_addr;
    } desc_info_t;

    // Bytes between consecutive descriptors: 8, 16 or 24.
    function automatic logic [4:0] desc_bytes(walk_cfg_t c);
        return 5'd8 + (c.wide ? 5'd8 : 5'd0) + (c.ext ? 5'd8 : 5'd0);
    endfunction

    // Words actually fetched per descriptor (the extension words are skipped).
    function automatic logic [1:0] fetch_count(walk_cfg_t c);
        return c.wide ? 2'd3 : 2'd2;
    endfunction

endpackage

// File: rtl/tx_desc_decode.sv
module tx_desc_decode
    import tx_walk_pkg::*;
(
    input  walk_cfg_t         cfg,
    input  logic [WORD_W-1:0] w0,
    input  logic [WORD_W-1:0] w1,
    input  logic [WORD_W-1:0] w2,
    output desc_info_t        info,
    output logic              bad
);
    logic unused_bits;
    assign unused_bits = ^{cfg.ext, w1[29:16], w1[14]};

    always_comb begin
        info.used     = w1[W1_USED_BIT];
        info.wrap     = w1[W1_WRAP_BIT];
        info.last     = w1[W1_LAST_BIT];
        info.len      = w1[LEN_W-1:0];
        info.buf_addr = {(cfg.wide ? w2 : {WORD_W{1'b0}}), w0};
        bad           = (info.buf_addr == '0) || (info.len == '0);
    end
endmodule

// File: rtl/tx_ptr_step.sv
module tx_ptr_step #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] base,
    input  logic              wrap,
    input  logic [4:0]        stride,
    output logic [ADDR_W-1:0] nxt
);
    assign nxt = wrap ? base : cur + ADDR_W'(stride);
endmodule

// File: rtl/tx_frame_budget.sv
module tx_frame_budget #(
    parameter int MAX_BYTES = 2048,
    parameter int LEN_W     = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             accept,
    input  logic [LEN_W-1:0] len,
    output logic             over
);
    localparam int CNT_W = $clog2(MAX_BYTES + 1);
    localparam int SUM_W = ((CNT_W > LEN_W) ? CNT_W : LEN_W) + 1;

    logic [CNT_W-1:0] total;
    logic [SUM_W-1:0] sum;

    assign sum  = SUM_W'(total) + SUM_W'(len);
    assign over = sum > SUM_W'(MAX_BYTES);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            total <= '0;
        end else if (accept) begin
            total <= CNT_W'(sum);
        end
    end
endmodule

// File: rtl/tx_desc_walker.sv
module tx_desc_walker
    import tx_walk_pkg::*;
#(
    parameter int ADDR_W          = 32,
    parameter int MAX_FRAME_BYTES = 2048
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       cfg_word,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic              start,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              frag_valid,
    output logic [63:0]       frag_addr,
    output logic [13:0]       frag_len,
    output logic              frag_last,
    output logic              frame_done,
    output logic              err_invalid,
    output logic              err_oversize,
    output logic [ADDR_W-1:0] q_ptr,
    output logic              busy
);
    walk_state_t       state;
    walk_cfg_t         cfg_q;
    walk_cfg_t         cfg_now;
    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] first_ptr;
    logic [ADDR_W-1:0] q_ptr_r;
    logic [ADDR_W-1:0] step_next;
    logic [1:0]        idx;
    logic              pending;
    logic [WORD_W-1:0] dw [FETCH_MAX];
    logic [WORD_W-1:0] fb_word;
    desc_info_t        info;
    logic              bad;
    logic              over;
    logic              launch;
    logic              accept;
    logic              budget_clr;
    logic              unused_cfg;

    assign unused_cfg   = ^{cfg_word[31], cfg_word[28:0]};
    assign cfg_now.wide = cfg_word[CFG_WIDE_BIT];
    assign cfg_now.ext  = cfg_word[CFG_EXT_BIT];

    assign launch     = (state == ST_IDLE) && (start || pending);
    assign accept     = (state == ST_EVAL) && !info.used && !bad && !over;
    assign budget_clr = launch || (state == ST_ADV);

    // Per-word capture registers for the fetched descriptor.
    for (genvar g = 0; g < FETCH_MAX; g++) begin : g_word
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (state == ST_RD_CAP && idx == 2'(g)) begin
                word_q <= mem_rdata;
            end
        end
        assign dw[g] = word_q;
    end

    tx_desc_decode u_dec (
        .cfg  (cfg_q),
        .w0   (dw[0]),
        .w1   (dw[1]),
        .w2   (dw[2]),
        .info (info),
        .bad  (bad)
    );

    tx_ptr_step #(.ADDR_W(ADDR_W)) u_step (
        .cur    (ptr),
        .base   (ring_base),
        .wrap   (info.wrap),
        .stride (desc_bytes(cfg_q)),
        .nxt    (step_next)
    );

    tx_frame_budget #(.MAX_BYTES(MAX_FRAME_BYTES), .LEN_W(LEN_W)) u_budget (
        .clk    (clk),
        .rst    (rst),
        .clear  (budget_clr),
        .accept (accept),
        .len    (info.len),
        .over   (over)
    );

    // Memory port driven from the sequencer state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ptr + ADDR_W'({idx, 2'b00});
        mem_wdata = fb_word;
        mem_wdata[W1_USED_BIT] = 1'b1;
        case (state)
            ST_RD_REQ: mem_req = 1'b1;
            ST_FB_REQ: begin
                mem_req  = 1'b1;
                mem_addr = first_ptr + ADDR_W'(4);
            end
            ST_FB_WR: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = first_ptr + ADDR_W'(4);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cfg_q     <= '0;
            ptr       <= '0;
            first_ptr <= '0;
            q_ptr_r   <= ring_base;
            idx       <= '0;
            pending   <= 1'b0;
            fb_word   <= '0;
        end else begin
            pending <= launch ? 1'b0 : (pending | start);
            case (state)
                ST_IDLE: begin
                    if (launch) begin
                        cfg_q     <= cfg_now;
                        ptr       <= q_ptr_r;
                        first_ptr <= q_ptr_r;
                        idx       <= '0;
                        state     <= ST_RD_REQ;
                    end
                end
                ST_RD_REQ: state <= ST_RD_CAP;
                ST_RD_CAP: begin
                    if (idx == fetch_count(cfg_q) - 2'd1) begin
                        state <= ST_EVAL;
                    end else begin
                        idx   <= idx + 2'd1;
                        state <= ST_RD_REQ;
                    end
                end
                ST_EVAL: begin
                    if (!accept) begin
                        state <= ST_IDLE;
                    end else if (info.last) begin
                        state <= ST_FB_REQ;
                    end else begin
                        ptr   <= step_next;
                        idx   <= '0;
                        state <= ST_RD_REQ;
                    end
                end
                ST_FB_REQ: state <= ST_FB_CAP;
                ST_FB_CAP: begin
                    fb_word <= mem_rdata;
                    state   <= ST_FB_WR;
                end
                ST_FB_WR: state <= ST_ADV;
                ST_ADV: begin
                    q_ptr_r   <= step_next;
                    ptr       <= step_next;
                    first_ptr <= step_next;
                    idx       <= '0;
                    state     <= ST_RD_REQ;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign frag_valid   = accept;
    assign frag_addr    = info.buf_addr;
    assign frag_len     = info.len;
    assign frag_last    = info.last;
    assign err_invalid  = (state == ST_EVAL) && !info.used && bad;
    assign err_oversize = (state == ST_EVAL) && !info.used && !bad && over;
    assign frame_done   = (state == ST_ADV);
    assign q_ptr        = q_ptr_r;
    assign busy         = (state != ST_IDLE);
endmodule

// File: rtl/tx_desc_walker_chk.sv
module tx_desc_walker_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_we,
    input logic [31:0]       mem_wdata,
    input logic              frag_valid,
    input logic [63:0]       frag_addr,
    input logic [13:0]       frag_len,
    input logic              frame_done,
    input logic              err_invalid,
    input logic              err_oversize,
    input logic [ADDR_W-1:0] q_ptr,
    input logic              busy
);
    // R5: no emitted fragment carries a zero address or zero length
    a_r5_frag_nonzero: assert property (@(posedge clk) disable iff (rst)
        frag_valid |-> (frag_addr != '0 && frag_len != '0));

    // R5, R9: a descriptor yields at most one outcome
    a_r9_one_outcome: assert property (@(posedge clk) disable iff (rst)
        $onehot0({frag_valid, err_invalid, err_oversize}));

    // R6: every write sets the released flag
    a_r6_wb_sets_used: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> mem_wdata[31]);

    // R6: frame completion follows the write-back
    a_r6_done_after_write: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> $past(mem_req && mem_we));

    // R7: the queue pointer only moves at a frame completion
    a_r7_qptr_on_done: assert property (@(posedge clk) disable iff (rst)
        !$stable(q_ptr) |-> $past(frame_done));

    // R3: activity only during a walk
    a_r3_outputs_when_busy: assert property (@(posedge clk) disable iff (rst)
        (frag_valid || frame_done || err_invalid || err_oversize || mem_req) |-> busy);
endmodule

bind tx_desc_walker tx_desc_walker_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tx_desc_walker_bench.sv
module tx_desc_walker_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_word = '0;
    logic [31:0] ring_base = '0;
    logic        start = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        frag_valid, frag_last, frame_done, err_invalid, err_oversize, busy;
    logic [63:0] frag_addr;
    logic [13:0] frag_len;
    logic [31:0] q_ptr;

    always #2 clk = ~clk;

    tx_desc_walker u_tx_desc_walker (.*);

    logic [31:0] mem [256];
    always @(posedge clk) begin
        if (mem_req && mem_we)  mem[mem_addr[9:2]] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[9:2]];
    end

    int total = 0;
    int bad = 0;

    // observed
    int          g_n, g_done, g_inv, g_ovs, g_rd, g_wr;
    logic [63:0] g_addr [512];
    logic [14:0] g_ll   [512];
    always @(negedge clk) begin
        if (!rst) begin
            if (frag_valid && g_n < 512) begin
                g_addr[g_n] = frag_addr;
                g_ll[g_n]   = {frag_len, frag_last};
                g_n++;
            end
            if (frame_done)   g_done++;
            if (err_invalid)  g_inv++;
            if (err_oversize) g_ovs++;
            if (mem_req && !mem_we) g_rd++;
            if (mem_req && mem_we)  g_wr++;
        end
    end

    // model
    logic [31:0] mm [256];
    int          e_n, e_done, e_inv, e_ovs, e_rd, e_wr;
    logic [63:0] e_addr [512];
    logic [14:0] e_ll   [512];
    logic [31:0] mq;

    task automatic check(input string tag, input logic [79:0] act, input logic [79:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk1(input bit used, input bit wrap, input bit last, input int len);
        logic [31:0] w = '0;
        w[31] = used; w[30] = wrap; w[15] = last; w[13:0] = len[13:0];
        return w;
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = '0;
    endtask

    task automatic put(input int a, input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2);
        mem[a / 4] = w0; mem[a / 4 + 1] = w1; mem[a / 4 + 2] = w2;
    endtask

    task automatic model_walk(input logic [31:0] cfg, input logic [31:0] base);
        logic wide;
        logic [31:0] p, first, nxt, w0, w1, w2;
        logic [63:0] a;
        int stride, cnt, len;
        wide = cfg[30];
        stride = 8 + (cfg[30] ? 8 : 0) + (cfg[29] ? 8 : 0);
        p = mq; first = mq; cnt = 0;
        for (int it = 0; it < 4000; it++) begin
            w0 = mm[p[9:2]];
            w1 = mm[p[9:2] + 8'd1];
            w2 = wide ? mm[p[9:2] + 8'd2] : 32'd0;
            e_rd += wide ? 3 : 2;
            if (w1[31]) break;
            a = wide ? {w2, w0} : {32'd0, w0};
            len = int'(w1[13:0]);
            if (a == 0 || len == 0) begin e_inv++; break; end
            if (cnt + len > 2048) begin e_ovs++; break; end
            if (e_n < 512) begin e_addr[e_n] = a; e_ll[e_n] = {w1[13:0], w1[15]}; end
            e_n++;
            cnt += len;
            nxt = w1[30] ? base : p + stride;
            if (w1[15]) begin
                e_rd++; e_wr++; e_done++;
                mm[first[9:2] + 8'd1][31] = 1'b1;
                mq = nxt; first = nxt; cnt = 0;
            end
            p = nxt;
        end
    endtask

    task automatic do_reset(input logic [31:0] base);
        rst = 1'b1; ring_base = base; start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_idle();
        int idle = 0;
        while (idle < 4) begin
            @(negedge clk);
            if (busy) idle = 0; else idle++;
        end
    endtask

    task automatic run_case(input string tag, input logic [31:0] cfg, input logic [31:0] base, input bit twice);
        int mis;
        do_reset(base);
        cfg_word = cfg;
        for (int i = 0; i < 256; i++) mm[i] = mem[i];
        e_n = 0; e_done = 0; e_inv = 0; e_ovs = 0; e_rd = 0; e_wr = 0; mq = base;
        g_n = 0; g_done = 0; g_inv = 0; g_ovs = 0; g_rd = 0; g_wr = 0;
        model_walk(cfg, base);
        if (twice) model_walk(cfg, base);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (twice) begin
            repeat (2) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        wait_idle();
        check({tag, " R4 fragment count"}, 80'(g_n), 80'(e_n));
        for (int i = 0; i < e_n && i < g_n && i < 512; i++) begin
            check({tag, " R4 fragment address"}, 80'(g_addr[i]), 80'(e_addr[i]));
            check({tag, " R4 fragment length/last"}, 80'(g_ll[i]), 80'(e_ll[i]));
        end
        check({tag, " R6 frames done"}, 80'(g_done), 80'(e_done));
        check({tag, " R6 write count"}, 80'(g_wr), 80'(e_wr));
        check({tag, " R5 invalid pulses"}, 80'(g_inv), 80'(e_inv));
        check({tag, " R9 oversize pulses"}, 80'(g_ovs), 80'(e_ovs));
        check({tag, " R3 read count"}, 80'(g_rd), 80'(e_rd));
        check({tag, " R7 queue pointer"}, 80'(q_ptr), 80'(mq));
        mis = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== mm[i]) mis++;
        check({tag, " R6 memory after write-back"}, 80'(mis), 80'(0));
    endtask

    initial begin
        #(4 * 150000);
        bad++; total++;
        $display("FAIL R3 watchdog act=running exp=idle");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        clear_mem();

        // R1: reset state
        do_reset(32'h0000_0140);
        @(negedge clk);
        check("R1 busy", 80'(busy), 80'(0));
        check("R1 queue pointer", 80'(q_ptr), 80'(32'h140));
        check("R1 outputs quiet", 80'({frag_valid, frame_done, err_invalid, err_oversize, mem_req}), 80'(0));

        // R11: two frames, then wrap back to a released descriptor
        clear_mem();
        put(32'h100, 32'h1000, mk1(0, 0, 0, 100), 0);
        put(32'h108, 32'h2000, mk1(0, 0, 1, 200), 0);
        put(32'h110, 32'h3000, mk1(0, 1, 1, 50), 0);
        run_case("R11 two frames", 32'h0, 32'h100, 0);

        // R2: wide addressing, stride 16 with upper address word
        clear_mem();
        put(32'h40, 32'h10, mk1(0, 0, 0, 64), 32'hAB);
        put(32'h50, 32'h20, mk1(0, 0, 1, 64), 32'hCD);
        run_case("R2 wide", 32'h4000_0000, 32'h40, 0);

        // R2: extended only, stride 16, two words fetched
        clear_mem();
        put(32'h80, 32'h111, mk1(0, 0, 1, 10), 32'hFFFF);
        put(32'h90, 32'h222, mk1(0, 1, 1, 20), 32'hFFFF);
        run_case("R2 extended", 32'h2000_0000, 32'h80, 0);

        // R2: both set, stride 24; other bits must not matter
        clear_mem();
        put(32'h00, 32'h333, mk1(0, 0, 1, 30), 32'h7);
        put(32'h18, 32'h444, mk1(0, 1, 1, 40), 32'h8);
        run_case("R2 both", 32'h6F5A_A5FF, 32'h00, 0);

        // R3: released descriptor at the head
        clear_mem();
        put(32'h100, 32'h1000, mk1(1, 0, 0, 5), 0);
        run_case("R3 released head", 32'h0, 32'h100, 0);

        // R5: zero length, then zero address, each after a valid fragment
        clear_mem();
        put(32'h100, 32'h1000, mk1(0, 0, 0, 40), 0);
        put(32'h108, 32'h2000, mk1(0, 0, 1, 0), 0);
        run_case("R5 zero length", 32'h0, 32'h100, 0);
        clear_mem();
        put(32'h100, 32'h1000, mk1(0, 0, 0, 40), 0);
        put(32'h108, 32'h0, mk1(0, 0, 1, 30), 0);
        run_case("R5 zero address", 32'h0, 32'h100, 0);

        // R9: exactly 2048 bytes is accepted, 2049 is not
        clear_mem();
        put(32'h100, 32'h1000, mk1(0, 0, 0, 1024), 0);
        put(32'h108, 32'h2000, mk1(0, 1, 1, 1024), 0);
        run_case("R9 at limit", 32'h0, 32'h100, 0);
        clear_mem();
        put(32'h100, 32'h1000, mk1(0, 0, 0, 1024), 0);
        put(32'h108, 32'h2000, mk1(0, 1, 1, 1025), 0);
        run_case("R9 over limit", 32'h0, 32'h100, 0);

        // R8: wrap inside a frame loops until the budget stops it
        clear_mem();
        put(32'h200, 32'h500, mk1(0, 0, 0, 300), 0);
        put(32'h208, 32'h600, mk1(0, 1, 0, 300), 0);
        run_case("R8 in-frame wrap", 32'h0, 32'h200, 0);

        // R10: second start during a walk is held and serviced
        clear_mem();
        put(32'h100, 32'h0, mk1(0, 0, 0, 8), 0);
        run_case("R10 held start", 32'h0, 32'h100, 1);

        // random rings
        for (int c = 0; c < 40; c++) begin
            logic [31:0] cfg, base, w1;
            int n, stride, len;
            cfg = $urandom;
            stride = 8 + (cfg[30] ? 8 : 0) + (cfg[29] ? 8 : 0);
            base = 32'(($urandom % 8) * 64);
            n = 1 + int'($urandom % 8);
            clear_mem();
            for (int i = 0; i < n; i++) begin
                len = ($urandom % 25 == 0) ? 0 : 1 + int'($urandom % 700);
                if ($urandom % 30 == 0) len = 1500;
                w1 = mk1(($urandom % 14) == 0, i == n - 1, (i == n - 1) || ($urandom % 3 == 0), len);
                put(int'(base) + i * stride, ($urandom % 25 == 0) ? 32'h0 : $urandom, w1, $urandom);
            end
            run_case("R4 random ring", cfg, base, c % 7 == 3);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule